// File: doc/BRIEF.md
# Burst-of-Four Dual-Port DDR SRAM Model

This block is a synthesizable, scaled-down model of a synchronous SRAM with a separate input bus and output bus. Every access moves a fixed burst of four words. A read port and a write port each have an active-low select. The two ports share one burst address, and the two low word-address bits are produced inside the block. Data moves on both edges of the single clock, so one burst takes two clock cycles. Each data beat carries its own per-lane byte enables.

Reads and writes run at the same time. The pipelines are coherent. A read returns the data of any write accepted on the same clock edge or earlier, merged lane by lane, even when that write has not yet reached the array. A write accepted after the read has no effect on it. In this model the output registers run on the input clock, which is the arrangement used when the separate output clocks are held high.

Top module: `qdr_b4_sram`

## Requirements
- R1: While `rst_n` is low, `rvalid` stays 0 and any bursts in flight are dropped. The storage array keeps its contents through reset, and commands are accepted again from the first rising edge after release.
- R2: `rd_n` and `wr_n` are active low and are sampled on the rising clock edge. A port accepts a command only if it did not accept one on the previous rising edge. Otherwise the command is ignored, and the array and `rvalid` do not change.
- R3: An accepted write takes four beats from `wdata`. They are sampled on the command's rising edge, the next falling edge, the next rising edge and the next falling edge. Beat j goes to word address {`addr`, j}, where the low two bits are 0, 1, 2 and 3 in that order.
- R4: `bw_n` is sampled with each write beat. Bit k low writes lane k, which is `wdata[k*L +: L]`, where L is 9 when the data width is a multiple of 9 and 8 otherwise. If the bit is high, that lane of the word keeps its old value.
- R5: For a read accepted on rising edge T, beat 0 appears on the falling edge 1.5 cycles after T. Beats 1, 2 and 3 follow on the next rising, falling and rising edges. Beat j is word {`addr`, j}. `rvalid` is high during exactly those four half-cycles.
- R6: A read returns the effect of every write accepted on the same rising edge or on an earlier one, merged lane by lane. This includes a same-edge write to the shared address. A write accepted on a later edge does not affect it.
- R7: Values on `wdata` and `bw_n` in half-cycles that belong to no accepted write burst have no effect on the array.
- R8: Reads accepted every second cycle produce a continuous stream, with `rvalid` high in every half-cycle and no two bursts overlapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges carry data |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read select, active low |
| wr_n | input | 1 | Write select, active low |
| addr | input | ADDR_W | Burst address shared by both ports |
| wdata | input | DATA_W | Write data beat |
| bw_n | input | DATA_W/L | Per-lane write enables, active low, one per beat |
| rdata | output | DATA_W | Read data beat |
| rvalid | output | 1 | High while `rdata` carries a read beat |

## Verification
A fault in the burst state counters shows up as a missing or misplaced `rvalid` half-cycle within four half-cycles of the command. It also shows up as a data beat landing in the wrong word, which becomes visible on the first read of that burst. A fault in the forwarding flag or the write staging registers only affects a read that meets an uncommitted write. It corrupts beat 0 or beat 1 of that read two cycles after the command. For that reason the stimulus pairs same-edge and adjacent-edge reads and writes at the same address, using random lane masks.

// File: rtl/qdr_b4_sram.sv
`timescale 1ns/1ps
module qdr_b4_sram #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/((DATA_W % 9 == 0) ? 9 : 8)-1:0] bw_n,
  output logic [DATA_W-1:0]   rdata,
  output logic                rvalid
);
  localparam int LANE_W = (DATA_W % 9 == 0) ? 9 : 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int WORDS  = 4 << ADDR_W;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
                                              input logic [DATA_W-1:0] new_w,
                                              input logic [LANES-1:0]  keep_n);
    logic [DATA_W-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*LANE_W +: LANE_W] = keep_n[l] ? old_w[l*LANE_W +: LANE_W] : new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [DATA_W-1:0] mem [WORDS];

  logic [1:0]        wst;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd0, wd1, wd2, wd3;
  logic [LANES-1:0]  wb0, wb1, wb2, wb3;
  logic              wr_go, commit;

  logic              s1_v, s1_f, s2_v, s2_f, s3_v;
  logic [ADDR_W-1:0] s1_a, s2_a, s3_a;
  logic              rd_go;

  logic [DATA_W-1:0] qr, qf;
  logic              vr, vf;

  assign wr_go  = !wr_n && (wst != 2'd1);
  assign commit = (wst == 2'd2);
  assign rd_go  = !rd_n && !s1_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      wst <= 2'd0;
    else if (wr_go)  wst <= 2'd1;
    else             wst <= (wst == 2'd1) ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (wr_go) begin
      wa  <= addr;
      wd0 <= wdata;
      wb0 <= bw_n;
    end
    if (wst == 2'd1) begin
      wd2 <= wdata;
      wb2 <= bw_n;
    end
  end

  always_ff @(negedge clk) begin
    if (wst == 2'd1) begin
      wd1 <= wdata;
      wb1 <= bw_n;
    end
    if (wst == 2'd2) begin
      wd3 <= wdata;
      wb3 <= bw_n;
    end
  end

  always_ff @(posedge clk)
    if (commit) begin
      mem[{wa, 2'd0}] <= merge(mem[{wa, 2'd0}], wd0, wb0);
      mem[{wa, 2'd1}] <= merge(mem[{wa, 2'd1}], wd1, wb1);
      mem[{wa, 2'd2}] <= merge(mem[{wa, 2'd2}], wd2, wb2);
      mem[{wa, 2'd3}] <= merge(mem[{wa, 2'd3}], wd3, wb3);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_f <= 1'b0; s1_a <= '0;
      s2_v <= 1'b0; s2_f <= 1'b0; s2_a <= '0;
      s3_v <= 1'b0; s3_a <= '0;
    end else begin
      s1_v <= rd_go; s1_f <= wr_go; s1_a <= addr;
      s2_v <= s1_v;  s2_f <= s1_f;  s2_a <= s1_a;
      s3_v <= s2_v;  s3_a <= s2_a;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      vf <= 1'b0;
      qf <= '0;
    end else if (s2_v) begin
      vf <= 1'b1;
      qf <= merge(mem[{s2_a, 2'd0}], wd0, s2_f ? wb0 : '1);
    end else if (s3_v) begin
      vf <= 1'b1;
      qf <= mem[{s3_a, 2'd2}];
    end else
      vf <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vr <= 1'b0;
      qr <= '0;
    end else if (s2_v) begin
      vr <= 1'b1;
      qr <= merge(mem[{s2_a, 2'd1}], wd1, s2_f ? wb1 : '1);
    end else if (s3_v) begin
      vr <= 1'b1;
      qr <= mem[{s3_a, 2'd3}];
    end else
      vr <= 1'b0;

  assign rdata  = clk ? qr : qf;
  assign rvalid = clk ? vr : vf;
endmodule

// File: rtl/qdr_b4_sram_chk.sv
`timescale 1ns/1ps
module qdr_b4_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_go,
  input logic wr_go,
  input logic commit,
  input logic s2_v,
  input logic s3_v,
  input logic fall_valid
);
  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> ##2 fall_valid ##1 fall_valid);

  assert_valid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fall_valid) |-> $past(rd_go, 2));

  assert_commit_after_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(wr_go, 2));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s2_v, s3_v}));

  assert_read_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go);
endmodule

bind qdr_b4_sram qdr_b4_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go),
  .commit(commit), .s2_v(s2_v), .s3_v(s3_v), .fall_valid(vf)
);

// File: tb/qdr_b4_sram_tb_top.sv
`timescale 1ns/1ps
module qdr_b4_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int LW = 9;
  localparam int NL = DW / LW;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdr_b4_sram #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .bw_n(bw_n), .rdata(rdata), .rvalid(rvalid)
  );

  int            n_tests = 0;
  int            n_fail = 0;
  logic [DW-1:0] mdl [NB*4];
  bit            ev [16];
  logic [DW-1:0] ed [16];
  int            k = 0;
  bit            rbusy = 0, wbusy = 0;
  logic [DW-1:0] cd [4];
  logic [NL-1:0] cb [4];
  string         req = "R1";

  task automatic chk(bit ok, string r, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] junk();
    logic [63:0] t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  task automatic sample(int h);
    chk(rvalid === ev[h%16], "R5", "rvalid", {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, ev[h%16]});
    if (ev[h%16]) chk(rdata === ed[h%16], req, "rdata", rdata, ed[h%16]);
    ev[h%16] = 1'b0;
  endtask

  task automatic cyc(bit rd, bit wr, int a, bit full);
    bit racc, wacc, wprev;
    if (k > 0) sample(2*k - 1);
    racc  = rd && !rbusy;
    wacc  = wr && !wbusy;
    wprev = wbusy;
    if (wacc)
      for (int j = 0; j < 4; j++) begin
        cd[j] = junk();
        cb[j] = full ? '0 : NL'($urandom());
        for (int l = 0; l < NL; l++)
          if (!cb[j][l]) mdl[a*4+j][l*LW +: LW] = cd[j][l*LW +: LW];
      end
    if (racc)
      for (int j = 0; j < 4; j++) begin
        ev[(2*k+3+j)%16] = 1'b1;
        ed[(2*k+3+j)%16] = mdl[a*4+j];
      end
    rd_n = !rd;
    wr_n = !wr;
    addr = AW'(a);
    if (wacc)       begin wdata = cd[0]; bw_n = cb[0]; end
    else if (wprev) begin wdata = cd[2]; bw_n = cb[2]; end
    else            begin wdata = junk(); bw_n = NL'($urandom()); end
    #(CLK_PERIOD/2);
    sample(2*k);
    if (wacc)       begin wdata = cd[1]; bw_n = cb[1]; end
    else if (wprev) begin wdata = cd[3]; bw_n = cb[3]; end
    else            begin wdata = junk(); bw_n = NL'($urandom()); end
    #(CLK_PERIOD/2);
    rbusy = racc;
    wbusy = wacc;
    k++;
  endtask

  task automatic do_reset();
    if (k > 0) sample(2*k - 1);
    rst_n = 1'b0;
    rd_n  = 1'b1;
    wr_n  = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #(CLK_PERIOD/2);
      chk(rvalid === 1'b0, "R1", "rvalid in reset", {{(DW-1){1'b0}}, rvalid}, '0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) ev[i] = 1'b0;
    rbusy = 0;
    wbusy = 0;
    k += 2;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_tests++;
    n_fail++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NB*4; i++) mdl[i] = '0;
    for (int i = 0; i < 16; i++) ev[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk(rvalid === 1'b0, "R1", "rvalid at reset", {{(DW-1){1'b0}}, rvalid}, '0);
    rst_n = 1'b1;

    req = "R3";
    for (int b = 0; b < NB; b++) begin cyc(0, 1, b, 1); cyc(0, 0, 0, 0); end
    for (int b = 0; b < NB; b++) begin cyc(1, 0, b, 0); cyc(0, 0, 0, 0); end

    req = "R4";
    for (int i = 0; i < 12; i++) begin
      int b = int'($urandom() % NB);
      cyc(0, 1, b, 0); cyc(0, 0, 0, 0); cyc(1, 0, b, 0); cyc(0, 0, 0, 0);
    end

    req = "R8";
    for (int i = 0; i < 12; i++) cyc(1, 0, i % NB, 0);
    repeat (4) cyc(0, 0, 0, 0);

    req = "R2";
    for (int i = 0; i < 16; i++) cyc(1, 1, int'($urandom() % NB), 0);
    for (int b = 0; b < NB; b++) begin cyc(1, 0, b, 0); cyc(0, 0, 0, 0); end

    req = "R6";
    for (int i = 0; i < 8; i++) begin
      int b = int'($urandom() % NB);
      cyc(1, 1, b, 0); cyc(0, 0, 0, 0);
      cyc(0, 1, b, 0); cyc(1, 0, b, 0); cyc(0, 0, 0, 0);
      cyc(1, 0, b, 0); cyc(0, 1, b, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    end

    req = "R7";
    for (int i = 0; i < 6; i++) begin
      int b = int'($urandom() % NB);
      cyc(0, 1, b, 0);
      repeat (5) cyc(0, 0, 0, 0);
      cyc(1, 0, b, 0); cyc(0, 0, 0, 0);
    end
    repeat (3) cyc(0, 0, 0, 0);

    req = "R1";
    cyc(1, 0, 2, 0);
    do_reset();
    for (int b = 0; b < NB; b++) begin cyc(1, 0, b, 0); cyc(0, 0, 0, 0); end

    req = "R6";
    for (int i = 0; i < 3000; i++)
      cyc(($urandom() % 10) < 5, ($urandom() % 10) < 5, int'($urandom() % NB), 0);
    repeat (5) cyc(0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule